// File: doc/BRIEF.md
# Floating-Point to Signed Integer Converter

This unit turns one IEEE 754 binary32 or binary64 operand into a signed 32-bit or 64-bit integer. One request is accepted per clock, and its result appears on registered outputs one cycle later. Each request either carries its own rounding direction (nearest-even, toward zero, upward, downward) or takes the direction from a small control register. The unit handles subnormal operands. It flags results that do not fit, and it raises an inexact flag when rounding changes the value.

An operand is invalid when it is NaN or infinite, or when its rounded value lies outside the destination range. A mode bit in the control register then picks how an invalid operand is reported. With the bit set, the result saturates: NaN gives zero, positive overflow gives the largest integer and negative overflow gives the most negative integer. With the bit clear, every invalid operand gives the single legacy pattern. A build parameter selects the newer or the older variant, and software writes cannot change the mode bit. The newer variant keeps the bit at 1 and the older variant keeps it at 0.

Top module: `fcvt_top`

## Requirements
- R1: A request with op_valid high at a rising edge produces res_valid high for exactly the following cycle, with res_data, res_invalid and res_inexact for that request. res_valid is low in any cycle whose previous edge had op_valid low.
- R2: With op_use_ctl low, op_rmode selects the rounding: 0 is nearest with ties to even, 1 is toward zero, 2 is toward plus infinity and 3 is toward minus infinity.
- R3: With op_use_ctl high, the rounding comes from control bits [1:0], using the same encoding as R2. The value used is the one held before the edge, so a control write in the same cycle does not affect that request.
- R4: A control write stores cfg_wr_data, except bit 18, which is forced to NEWER_VARIANT. After reset, ctl_q is 0x00040000 when NEWER_VARIANT=1 and 0x00000000 otherwise.
- R5: With op_to_long low, the valid range is [-2^31, 2^31-1], the result sits in bits [31:0] and bits [63:32] read zero. With op_to_long high, the valid range is [-2^63, 2^63-1] over all 64 bits.
- R6: With op_is_double high, op_src is a binary64 value. With it low, bits [31:0] hold a binary32 value. Subnormals of both formats convert by their exact value.
- R7: res_invalid is high exactly when the operand is NaN or infinite, or when its rounded value lies outside the R5 range.
- R8: With bit 18 of ctl_q set, an invalid NaN gives zero. An invalid operand with the sign bit clear gives 0x7FFFFFFF for a word and 0x7FFFFFFFFFFFFFFF for a long. An invalid operand with the sign bit set gives 0x80000000 for a word and 0x8000000000000000 for a long.
- R9: With bit 18 of ctl_q clear, every invalid operand gives 0x7FFFFFFF for a word or 0x7FFFFFFFFFFFFFFF for a long, whatever its sign or NaN-ness.
- R10: res_inexact is high exactly when the result is valid and the rounded integer differs from the operand value. It is never high together with res_invalid.
- R11: After synchronous reset, res_valid, res_invalid and res_inexact are 0 and res_data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 32 | Control register write value |
| ctl_q | output | 32 | Current control register value |
| op_valid | input | 1 | Conversion request |
| op_is_double | input | 1 | 1: binary64 operand, 0: binary32 in bits [31:0] |
| op_to_long | input | 1 | 1: 64-bit destination, 0: 32-bit destination |
| op_use_ctl | input | 1 | 1: rounding from control bits [1:0] |
| op_rmode | input | 2 | Per-request rounding direction |
| op_src | input | 64 | Operand bits |
| res_valid | output | 1 | Result strobe |
| res_data | output | 64 | Converted integer |
| res_invalid | output | 1 | Invalid-operation flag |
| res_inexact | output | 1 | Inexact flag |

## Verification
The hardest cases to reach from the ports are operands whose pre-rounding magnitude lies just inside a destination bound while rounding carries it across. Examples are 2^31-0.5 under nearest-even and -2^31-0.5, which ties back to an even value inside the range. Exactly ±2^31 and ±2^63 show whether the bound comparison is off by one. The stimulus places these values directly under every rounding direction and both destination widths, then adds random operands with exponents clustered around the integer bounds. It also issues a control write in the same cycle as a request that reads the rounding direction from the control register.

// File: rtl/fcvt_pkg.sv
`timescale 1ns/1ps
package fcvt_pkg;
  localparam int IW      = 64;             // widest destination and operand width
  localparam int WW      = 32;             // narrow destination and binary32 width
  localparam int DEXP_W  = 11;
  localparam int DFRAC_W = 52;
  localparam int DBIAS   = 1023;
  localparam int SEXP_W  = 8;
  localparam int SFRAC_W = 23;
  localparam int SBIAS   = 127;
  localparam int MW      = DFRAC_W + 1;    // significand with hidden bit
  localparam int EW      = 13;             // signed unbiased exponent width

  typedef logic signed [EW-1:0] sexp_t;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  typedef struct packed {
    logic          sign;
    logic          is_nan;
    logic          is_inf;
    sexp_t         exp;
    logic [MW-1:0] mant;
  } unp_t;
endpackage

// File: rtl/fcvt_ctl.sv
`timescale 1ns/1ps
module fcvt_ctl #(
  parameter int CTL_W     = 32,
  parameter int N2008_BIT = 18,
  parameter bit NEWER     = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  output logic [CTL_W-1:0] ctl_q
);
  localparam logic [CTL_W-1:0] N_MASK = CTL_W'(1) << N2008_BIT;

  logic [CTL_W-1:0] forced;
  logic [CTL_W-1:0] rst_val;

  generate
    if (NEWER) begin : g_newer
      assign forced  = wr_data | N_MASK;
      assign rst_val = N_MASK;
    end else begin : g_older
      assign forced  = wr_data & ~N_MASK;
      assign rst_val = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        ctl_q <= rst_val;
    else if (wr_en) ctl_q <= forced;
  end
endmodule

// File: rtl/fcvt_unpack.sv
`timescale 1ns/1ps
module fcvt_unpack
  import fcvt_pkg::*;
(
  input  logic [IW-1:0] src,
  input  logic          is_dbl,
  output unp_t          u
);
  logic [DEXP_W-1:0]  de;
  logic [DFRAC_W-1:0] df;
  logic [SEXP_W-1:0]  se;
  logic [SFRAC_W-1:0] sf;

  assign de = src[IW-2 -: DEXP_W];
  assign df = src[DFRAC_W-1:0];
  assign se = src[WW-2 -: SEXP_W];
  assign sf = src[SFRAC_W-1:0];

  always_comb begin
    if (is_dbl) begin
      u.sign   = src[IW-1];
      u.is_nan = (&de) & (|df);
      u.is_inf = (&de) & ~(|df);
      u.exp    = ((de == '0) ? sexp_t'(1) : sexp_t'(de)) - sexp_t'(DBIAS);
      u.mant   = {|de, df};
    end else begin
      u.sign   = src[WW-1];
      u.is_nan = (&se) & (|sf);
      u.is_inf = (&se) & ~(|sf);
      u.exp    = ((se == '0) ? sexp_t'(1) : sexp_t'(se)) - sexp_t'(SBIAS);
      u.mant   = {|se, sf, {(MW-1-SFRAC_W){1'b0}}};
    end
  end
endmodule

// File: rtl/fcvt_round.sv
`timescale 1ns/1ps
module fcvt_round
  import fcvt_pkg::*;
(
  input  logic          sign,
  input  sexp_t         exp,
  input  logic [MW-1:0] mant,
  input  rmode_e        rm,
  output logic [IW:0]   mag,
  output logic          lost,
  output logic          huge
);
  // value = mant * 2^(exp - DFRAC_W); placed so bit PT is weight 2^0
  localparam int WIDE = MW + 2*IW - 1;
  localparam int SH_W = $clog2(2*IW);
  localparam int PT   = DFRAC_W + IW;

  logic [WIDE-1:0] wide;
  logic [SH_W-1:0] sh;
  logic            tiny;
  logic [IW-1:0]   ipart;
  logic            g;
  logic            st;
  logic            inc;

  always_comb begin
    huge = (exp >= sexp_t'(IW));
    tiny = (exp < -sexp_t'(IW));
    sh   = SH_W'(exp + sexp_t'(IW));
    wide = {{(WIDE-MW){1'b0}}, mant} << sh;
    if (tiny) begin
      ipart = '0;
      g     = 1'b0;
      st    = |mant;
    end else begin
      ipart = wide[PT+IW-1:PT];
      g     = wide[PT-1];
      st    = |wide[PT-2:0];
    end
    unique case (rm)
      RM_NEAR: inc = g & (st | ipart[0]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = (g | st) & ~sign;
      default: inc = (g | st) & sign;
    endcase
    mag  = {1'b0, ipart} + {{IW{1'b0}}, inc};
    lost = g | st;
  end
endmodule

// File: rtl/fcvt_sat.sv
`timescale 1ns/1ps
module fcvt_sat
  import fcvt_pkg::*;
(
  input  logic          sign,
  input  logic          is_nan,
  input  logic          is_inf,
  input  logic [IW:0]   mag,
  input  logic          huge,
  input  logic          lost,
  input  logic          to_long,
  input  logic          nan2008,
  output logic [IW-1:0] data,
  output logic          invalid,
  output logic          inexact
);
  localparam logic [IW:0]   L_POS_LIM = {2'b00, {(IW-1){1'b1}}};
  localparam logic [IW:0]   L_NEG_LIM = {2'b01, {(IW-1){1'b0}}};
  localparam logic [IW:0]   W_POS_LIM = {{(IW-WW+2){1'b0}}, {(WW-1){1'b1}}};
  localparam logic [IW:0]   W_NEG_LIM = {{(IW-WW+1){1'b0}}, 1'b1, {(WW-1){1'b0}}};
  localparam logic [IW-1:0] L_POS_PAT = {1'b0, {(IW-1){1'b1}}};
  localparam logic [IW-1:0] L_NEG_PAT = {1'b1, {(IW-1){1'b0}}};
  localparam logic [IW-1:0] W_POS_PAT = {{(IW-WW+1){1'b0}}, {(WW-1){1'b1}}};
  localparam logic [IW-1:0] W_NEG_PAT = {{(IW-WW){1'b0}}, 1'b1, {(WW-1){1'b0}}};

  logic [IW:0]   pos_lim;
  logic [IW:0]   neg_lim;
  logic          over;
  logic [IW-1:0] sval;
  logic [IW-1:0] pos_pat;
  logic [IW-1:0] neg_pat;

  always_comb begin
    pos_lim = to_long ? L_POS_LIM : W_POS_LIM;
    neg_lim = to_long ? L_NEG_LIM : W_NEG_LIM;
    pos_pat = to_long ? L_POS_PAT : W_POS_PAT;
    neg_pat = to_long ? L_NEG_PAT : W_NEG_PAT;
    over    = huge | (sign ? (mag > neg_lim) : (mag > pos_lim));
    invalid = is_nan | is_inf | over;
    sval    = sign ? ((~mag[IW-1:0]) + {{(IW-1){1'b0}}, 1'b1}) : mag[IW-1:0];
    if (invalid) begin
      inexact = 1'b0;
      if (!nan2008)   data = pos_pat;
      else if (is_nan) data = '0;
      else if (sign)   data = neg_pat;
      else             data = pos_pat;
    end else begin
      inexact = lost;
      data    = to_long ? sval : {{(IW-WW){1'b0}}, sval[WW-1:0]};
    end
  end
endmodule

// File: rtl/fcvt_top.sv
`timescale 1ns/1ps
module fcvt_top
  import fcvt_pkg::*;
#(
  parameter bit NEWER_VARIANT = 1'b1,
  parameter int CTL_W         = 32,
  parameter int RM_LSB        = 0,
  parameter int N2008_BIT     = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr_en,
  input  logic [CTL_W-1:0] cfg_wr_data,
  output logic [CTL_W-1:0] ctl_q,
  input  logic             op_valid,
  input  logic             op_is_double,
  input  logic             op_to_long,
  input  logic             op_use_ctl,
  input  logic [1:0]       op_rmode,
  input  logic [IW-1:0]    op_src,
  output logic             res_valid,
  output logic [IW-1:0]    res_data,
  output logic             res_invalid,
  output logic             res_inexact
);
  unp_t          u;
  rmode_e        rm;
  logic [IW:0]   mag;
  logic          lost;
  logic          huge;
  logic [IW-1:0] c_data;
  logic          c_invalid;
  logic          c_inexact;

  fcvt_ctl #(
    .CTL_W(CTL_W), .N2008_BIT(N2008_BIT), .NEWER(NEWER_VARIANT)
  ) u_ctl (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data), .ctl_q(ctl_q)
  );

  fcvt_unpack u_unp (.src(op_src), .is_dbl(op_is_double), .u(u));

  assign rm = rmode_e'(op_use_ctl ? ctl_q[RM_LSB +: 2] : op_rmode);

  fcvt_round u_rnd (
    .sign(u.sign), .exp(u.exp), .mant(u.mant), .rm(rm),
    .mag(mag), .lost(lost), .huge(huge)
  );

  fcvt_sat u_sat (
    .sign(u.sign), .is_nan(u.is_nan), .is_inf(u.is_inf), .mag(mag),
    .huge(huge), .lost(lost), .to_long(op_to_long), .nan2008(ctl_q[N2008_BIT]),
    .data(c_data), .invalid(c_invalid), .inexact(c_inexact)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_invalid <= 1'b0;
      res_inexact <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_data    <= c_data;
        res_invalid <= c_invalid;
        res_inexact <= c_inexact;
      end
    end
  end
endmodule

// File: rtl/fcvt_chk.sv
`timescale 1ns/1ps
module fcvt_chk
  import fcvt_pkg::*;
#(
  parameter bit NEWER_VARIANT = 1'b1,
  parameter int CTL_W         = 32,
  parameter int N2008_BIT     = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_wr_en,
  input logic [CTL_W-1:0] cfg_wr_data,
  input logic [CTL_W-1:0] ctl_q,
  input logic             op_valid,
  input logic             op_is_double,
  input logic             op_to_long,
  input logic [IW-1:0]    op_src,
  input logic             res_valid,
  input logic [IW-1:0]    res_data,
  input logic             res_invalid,
  input logic             res_inexact
);
  localparam logic [CTL_W-1:0] KEEP = ~(CTL_W'(1) << N2008_BIT);
  localparam logic [IW-1:0] L_LEG = {1'b0, {(IW-1){1'b1}}};
  localparam logic [IW-1:0] W_LEG = {{(IW-WW+1){1'b0}}, {(WW-1){1'b1}}};

  logic src_nan;
  assign src_nan = op_is_double ?
    ((&op_src[IW-2 -: DEXP_W]) & (|op_src[DFRAC_W-1:0])) :
    ((&op_src[WW-2 -: SEXP_W]) & (|op_src[SFRAC_W-1:0]));

  assert_res_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);
  assert_no_spurious_res_R1: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !res_valid);
  assert_ctl_write_forced_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_wr_en |=> ((ctl_q[N2008_BIT] == NEWER_VARIANT) &&
                   ((ctl_q & KEEP) == ($past(cfg_wr_data) & KEEP))));
  assert_word_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_to_long) |=> (res_data[IW-1:WW] == '0));
  assert_nan_flagged_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && src_nan) |=> res_invalid);
  assert_nan_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (NEWER_VARIANT && op_valid && src_nan) |=> (res_data == '0));
  assert_legacy_pattern_R9: assert property (@(posedge clk) disable iff (rst)
    (!NEWER_VARIANT && op_valid) |=>
      (!res_invalid || (res_data == ($past(op_to_long) ? L_LEG : W_LEG))));
  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    res_invalid |-> !res_inexact);
endmodule

bind fcvt_top fcvt_chk #(
  .NEWER_VARIANT(NEWER_VARIANT), .CTL_W(CTL_W), .N2008_BIT(N2008_BIT)
) u_chk (
  .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
  .ctl_q(ctl_q), .op_valid(op_valid), .op_is_double(op_is_double),
  .op_to_long(op_to_long), .op_src(op_src), .res_valid(res_valid),
  .res_data(res_data), .res_invalid(res_invalid), .res_inexact(res_inexact)
);

// File: tb/sim_fcvt_top.sv
`timescale 1ns/1ps
module sim_fcvt_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, cfg_wr_en, op_valid, op_is_double, op_to_long, op_use_ctl;
  logic [31:0] cfg_wr_data;
  logic [1:0]  op_rmode;
  logic [63:0] op_src;
  logic [31:0] ctl0, ctl1;
  logic        rv0, ri0, rx0, rv1, ri1, rx1;
  logic [63:0] rd0, rd1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] cm0, cm1;   // expected control values

  fcvt_top #(.NEWER_VARIANT(1'b1)) u0 (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .ctl_q(ctl0),
    .op_valid(op_valid), .op_is_double(op_is_double), .op_to_long(op_to_long),
    .op_use_ctl(op_use_ctl), .op_rmode(op_rmode), .op_src(op_src),
    .res_valid(rv0), .res_data(rd0), .res_invalid(ri0), .res_inexact(rx0));

  fcvt_top #(.NEWER_VARIANT(1'b0)) u1 (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .ctl_q(ctl1),
    .op_valid(op_valid), .op_is_double(op_is_double), .op_to_long(op_to_long),
    .op_use_ctl(op_use_ctl), .op_rmode(op_rmode), .op_src(op_src),
    .res_valid(rv1), .res_data(rd1), .res_invalid(ri1), .res_inexact(rx1));

  task automatic chk(input string tag, input logic [67:0] act, input logic [67:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_nan_in(input logic [63:0] s, input bit dbl);
    if (dbl) return (s[62:52] == 11'h7FF) && (s[51:0] != 0);
    return (s[30:23] == 8'hFF) && (s[22:0] != 0);
  endfunction

  function automatic real to_real(input logic [63:0] s, input bit dbl);
    real m;
    if (dbl) return $bitstoreal(s);
    if (s[30:23] == 8'hFF) return $bitstoreal({s[31], 11'h7FF, s[22:0], 29'b0});
    if (s[30:23] == 0) m = real'(s[22:0]) * (2.0 ** (-149.0));
    else m = (8388608.0 + real'(s[22:0])) * (2.0 ** (real'(s[30:23]) - 150.0));
    return s[31] ? -m : m;
  endfunction

  function automatic real rnd(input real r, input logic [1:0] m);
    real f, d;
    case (m)
      2'd0: begin
        f = $floor(r); d = r - f;
        if (d > 0.5) f = f + 1.0;
        else if (d == 0.5 && ($floor(f / 2.0) * 2.0 != f)) f = f + 1.0;
        return f;
      end
      2'd1: return (r < 0.0) ? $ceil(r) : $floor(r);
      2'd2: return $ceil(r);
      default: return $floor(r);
    endcase
  endfunction

  // expected {valid, invalid, inexact, data}
  function automatic logic [67:0] model(input logic [63:0] s, input bit dbl, input bit lng,
                                        input logic [1:0] m, input bit n2008);
    real lim, r, q;
    logic [63:0] pp, np, d;
    longint v;
    lim = lng ? 2.0 ** 63 : 2.0 ** 31;
    pp  = lng ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
    np  = lng ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
    if (is_nan_in(s, dbl)) return {4'b0110, n2008 ? 64'd0 : pp};
    r = to_real(s, dbl);
    q = rnd(r, m);
    if (q >= lim || q < -lim) return {4'b0110, (n2008 && q < 0.0) ? np : pp};
    v = longint'(q);
    d = lng ? v : {32'd0, v[31:0]};
    return {2'b01, 1'b0, (q != r), d};
  endfunction

  function automatic logic [31:0] force_ctl(input logic [31:0] d, input bit newer);
    return newer ? (d | 32'h0004_0000) : (d & ~32'h0004_0000);
  endfunction

  // one request; optional control write in the same cycle
  task automatic op(input string tag, input logic [63:0] s, input bit dbl, input bit lng,
                    input bit uc, input logic [1:0] m, input bit wr, input logic [31:0] wd);
    logic [67:0] e0, e1;
    @(negedge clk);
    op_valid = 1; op_src = s; op_is_double = dbl; op_to_long = lng;
    op_use_ctl = uc; op_rmode = m; cfg_wr_en = wr; cfg_wr_data = wd;
    e0 = model(s, dbl, lng, uc ? cm0[1:0] : m, cm0[18]);
    e1 = model(s, dbl, lng, uc ? cm1[1:0] : m, cm1[18]);
    @(posedge clk); #1;
    op_valid = 0; cfg_wr_en = 0;
    if (wr) begin cm0 = force_ctl(wd, 1'b1); cm1 = force_ctl(wd, 1'b0); end
    chk({tag, e0[66] ? " R7 R8" : " R2"}, {rv0, ri0, rx0, rd0}, {1'b0, e0[66:0]});
    chk({tag, e1[66] ? " R7 R9" : " R2"}, {rv1, ri1, rx1, rd1}, {1'b0, e1[66:0]});
  endtask

  task automatic wr_ctl(input logic [31:0] wd);
    @(negedge clk);
    cfg_wr_en = 1; cfg_wr_data = wd;
    @(posedge clk); #1;
    cfg_wr_en = 0;
    cm0 = force_ctl(wd, 1'b1); cm1 = force_ctl(wd, 1'b0);
    chk("R4 ctl newer", {36'd0, ctl0}, {36'd0, cm0});
    chk("R4 ctl older", {36'd0, ctl1}, {36'd0, cm1});
  endtask

  task automatic idle_chk;
    @(negedge clk); op_valid = 0;
    @(posedge clk); #1;
    chk("R1 idle", {66'd0, rv0, rv1}, 68'd0);
  endtask

  logic [63:0] dv [24];
  logic [63:0] sv [14];

  initial begin
    dv = '{64'h3FF8000000000000, 64'h4004000000000000, 64'hBFF8000000000000,
           64'hC004000000000000, 64'h3FD3333333333333, 64'hBFD3333333333333,
           64'h0000000000000000, 64'h8000000000000000, 64'h41DFFFFFFFC00000,
           64'h41DFFFFFFFE00000, 64'h41E0000000000000, 64'hC1E0000000000000,
           64'hC1E0000000100000, 64'hC1E0000000200000, 64'h43DFFFFFFFFFFFFF,
           64'h43E0000000000000, 64'hC3E0000000000000, 64'hC3E0000000000001,
           64'h7FF0000000000000, 64'hFFF0000000000000, 64'h7FF8000000000000,
           64'hFFF0000000000001, 64'h0000000000000001, 64'h800FFFFFFFFFFFFF};
    sv = '{64'h3FC00000, 64'hC0200000, 64'h3F000000, 64'hBF400000, 64'h4F000000,
           64'hCF000000, 64'h4EFFFFFF, 64'h5F000000, 64'hDF000000, 64'h7F800000,
           64'hFF800000, 64'h7FC00000, 64'h00000001, 64'h80000001};
    rst = 1; cfg_wr_en = 0; cfg_wr_data = 0; op_valid = 0; op_is_double = 0;
    op_to_long = 0; op_use_ctl = 0; op_rmode = 0; op_src = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    cm0 = 32'h0004_0000; cm1 = 32'h0;
    chk("R11 reset outputs", {rv0, ri0, rx0, rd0, rv1}, 68'd0);
    chk("R11 reset outputs older", {rv1, ri1, rx1, rd1, 1'b0}, 68'd0);
    chk("R4 reset ctl", {4'd0, ctl0, ctl1}, {4'd0, 32'h0004_0000, 32'h0});
    idle_chk();

    for (int i = 0; i < 24; i++)
      for (int m = 0; m < 4; m++)
        for (int l = 0; l < 2; l++)
          op("R5 double", dv[i], 1'b1, l[0], 1'b0, m[1:0], 1'b0, 32'd0);
    for (int i = 0; i < 14; i++)
      for (int m = 0; m < 4; m++)
        for (int l = 0; l < 2; l++)
          op("R6 single", sv[i], 1'b0, l[0], 1'b0, m[1:0], 1'b0, 32'd0);
    idle_chk();

    for (int m = 0; m < 4; m++) begin
      wr_ctl(32'hABC0_0000 | m);
      for (int i = 0; i < 14; i++)
        op("R3 ctl mode", dv[i], 1'b1, 1'b0, 1'b1, ~m[1:0], 1'b0, 32'd0);
    end
    wr_ctl(32'hFFFF_FFFF);
    wr_ctl(32'h0000_0003);
    op("R3 same-cycle write", 64'h4004000000000000, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 32'h2);
    op("R3 after write", 64'h4004000000000000, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 32'h0);
    chk("R4 ctl after same-cycle write", {4'd0, ctl0, ctl1}, {4'd0, cm0, cm1});

    for (int k = 0; k < 3000; k++) begin
      logic [63:0] s;
      bit dbl;
      dbl = k[0];
      if (dbl)
        s = {1'($urandom), 11'(1023 + ($urandom % 141) - 70), $urandom, 20'($urandom)};
      else
        s = {32'd0, 1'($urandom), 8'(127 + ($urandom % 71) - 35), 23'($urandom)};
      op("R10 random", s, dbl, 1'($urandom), 1'b0, 2'($urandom), 1'b0, 32'd0);
    end
    idle_chk();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule